// File: doc/BRIEF.md
# Card Bus Clock Generator

This block derives the clock driven onto a memory-card bus from a faster peripheral clock. The clock passes through two division stages in series. The first stage is a power-of-two prescaler that software can bypass. The second is a small integer divider. Software programs both stages through a rate register. It starts, stops and soft-resets the clock through a control register, using one shared write port.

The block produces the card clock as a registered waveform and a one-cycle enable strobe in the peripheral clock domain, once per card period. Logic that runs at the card rate but stays on the peripheral clock uses this strobe. A status flag shows whether the card clock is running.

Start and stop requests are held pending until a card period ends. The clock therefore never produces a shortened high or low phase. Choosing the stage values for a target frequency is left to software.

Top module: `cardclk_gen`

## Requirements
- R1: After reset, card_clk, card_ce and clk_run are all low.
- R2: A write with wr_sel=1 loads the rate register. wr_data[3:0] is the divider value d, and wr_data[15:4] is the prescaler value P. One card period lasts (d+1)×F input cycles, where F=1 when P=0 and F=2×P otherwise.
- R3: A divider value of 0 behaves exactly like a divider value of 1.
- R4: With D=d+1 and H=floor(D/2), each card period starts with a low phase of H×F input cycles, followed by a high phase of (D−H)×F input cycles.
- R5: A nonzero prescaler value that is not a power of two acts as the largest power of two below it. For example, 3 acts as 2, 5 as 4, and 0xFFF as 0x800.
- R6: While the clock runs, card_ce is high for exactly one input cycle per card period. That cycle is the last input cycle of the high phase. card_ce is never high outside a high phase.
- R7: A control write (wr_sel=0) with bit 1 set requests start. The clock begins at the next period boundary with a low phase, and clk_run goes high at that boundary.
- R8: A control write with bit 0 set requests stop. The current high phase completes at full length, and then card_clk stays low and clk_run falls. If bit 0 and bit 1 are set in the same write, the stop wins.
- R9: A control write with bit 3 set is a soft reset. From the next cycle, clk_run and card_clk are low and the division counters are cleared. The clock stays stopped until a later start request, and any start bit in the same write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = control, 1 = rate |
| wr_data | input | 16 | Write data |
| card_clk | output | 1 | Generated card bus clock |
| card_ce | output | 1 | One-cycle strobe per card period |
| clk_run | output | 1 | Card clock running status |

## Verification
The bench sweeps every divider value, including the illegal zero. Each divider is combined with a bypassed prescaler, power-of-two prescalers and non-power-of-two prescalers, and for each pair it measures the low phase, the high phase and the position of the strobe. Odd divisor totals show whether the uneven split puts the extra unit in the high phase. Non-power-of-two prescalers, together with the largest field value, show whether the prescaler rounds down or uses the raw value. Separate runs check three control cases: a stop issued at the start of a high phase, a combined stop-and-start write, and a soft reset both alone and together with a start. Each of these shows whether a phase is ever cut short, and whether the clock restarts without an explicit request.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
    localparam int PRE_W    = 12;
    localparam int DIV_W    = 4;
    localparam int RATE_W   = PRE_W + DIV_W;
    localparam int PCNT_W   = PRE_W + 1;
    localparam int CTL_STOP  = 0;
    localparam int CTL_START = 1;
    localparam int CTL_SRST  = 3;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
    } rate_t;

    typedef struct packed {
        logic [DIV_W-1:0] dcnt;
        logic             run;
        logic             pend_start;
        logic             pend_stop;
        logic             clk;
    } div_st_t;
endpackage

// File: rtl/cardclk_regs.sv
module cardclk_regs
    import cardclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [RATE_W-1:0] wr_data,
    output rate_t             rate,
    output logic              req_start,
    output logic              req_stop,
    output logic              req_srst
);
    rate_t rate_d, rate_q;
    logic  ctl_wr;

    always_comb begin
        rate_d = rate_q;
        if (wr_en && wr_sel)
            rate_d = rate_t'(wr_data);
        ctl_wr    = wr_en && !wr_sel;
        // soft reset masks the other bits; stop masks start
        req_srst  = ctl_wr && wr_data[CTL_SRST];
        req_stop  = ctl_wr && wr_data[CTL_STOP] && !wr_data[CTL_SRST];
        req_start = ctl_wr && wr_data[CTL_START] && !wr_data[CTL_STOP]
                    && !wr_data[CTL_SRST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rate_q <= '{pre: '0, div: DIV_W'(1)};
        else        rate_q <= rate_d;
    end

    assign rate = rate_q;
endmodule

// File: rtl/cardclk_prescale.sv
module cardclk_prescale
    import cardclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    logic [PCNT_W-1:0] pcnt_d, pcnt_q;
    logic [PRE_W-1:0]  pow2;
    logic [PCNT_W-1:0] lim;
    logic              bypass;

    always_comb begin
        // keep only the highest set bit: floor to a power of two
        pow2 = '0;
        for (int i = 0; i < PRE_W; i++)
            if (pre[i]) pow2 = PRE_W'(1) << i;
        bypass = (pre == '0);
        lim    = {pow2, 1'b0} - PCNT_W'(1);
        tick   = bypass || (pcnt_q >= lim);
        if (clr || tick) pcnt_d = '0;
        else             pcnt_d = pcnt_q + PCNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end
endmodule

// File: rtl/cardclk_divider.sv
module cardclk_divider
    import cardclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic             req_start,
    input  logic             req_stop,
    input  logic [DIV_W-1:0] div,
    output logic             card_clk,
    output logic             card_ce,
    output logic             running
);
    div_st_t st_d, st_q;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W:0]   half;
    logic             wrap;

    always_comb begin
        div_eff = (div == '0) ? DIV_W'(1) : div;
        half    = ({1'b0, div_eff} + (DIV_W+1)'(1)) >> 1;
        wrap    = tick && (st_q.dcnt >= div_eff);
        st_d    = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (tick)
                st_d.dcnt = wrap ? '0 : st_q.dcnt + DIV_W'(1);
            if (wrap) begin
                if (st_q.pend_stop)       st_d.run = 1'b0;
                else if (st_q.pend_start) st_d.run = 1'b1;
                st_d.pend_start = 1'b0;
                st_d.pend_stop  = 1'b0;
            end
            if (req_stop) begin
                st_d.pend_stop  = 1'b1;
                st_d.pend_start = 1'b0;
            end else if (req_start) begin
                st_d.pend_start = 1'b1;
                st_d.pend_stop  = 1'b0;
            end
        end
        st_d.clk = st_d.run && ({1'b0, st_d.dcnt} >= half);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign card_clk = st_q.clk;
    assign running  = st_q.run;
    assign card_ce  = st_q.run && wrap;
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
    import cardclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [RATE_W-1:0] wr_data,
    output logic              card_clk,
    output logic              card_ce,
    output logic              clk_run
);
    rate_t rate;
    logic  req_start, req_stop, req_srst, tick;

    cardclk_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rate(rate), .req_start(req_start),
        .req_stop(req_stop), .req_srst(req_srst)
    );

    cardclk_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .clr(req_srst), .pre(rate.pre), .tick(tick)
    );

    cardclk_divider u_div (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(req_srst),
        .req_start(req_start), .req_stop(req_stop), .div(rate.div),
        .card_clk(card_clk), .card_ce(card_ce), .running(clk_run)
    );
endmodule

// File: rtl/cardclk_chk.sv
module cardclk_chk
    import cardclk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [RATE_W-1:0] wr_data,
    input logic              card_clk,
    input logic              card_ce,
    input logic              clk_run
);
    a_r7_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_run) |-> !card_clk);
    a_r7_clk_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        card_clk |-> clk_run);
    a_r8_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_run) |-> !card_clk);
    a_r6_ce_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        card_ce |-> card_clk);
    a_r6_ce_single: assert property (@(posedge clk) disable iff (!rst_n)
        card_ce |=> !card_ce);
    a_r6_ce_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
        card_ce |=> !card_clk);
    a_r9_sreset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[CTL_SRST]) |=> (!clk_run && !card_clk));
endmodule

bind cardclk_gen cardclk_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .card_clk(card_clk), .card_ce(card_ce),
    .clk_run(clk_run)
);

// File: tb/sim_cardclk_gen.sv
module sim_cardclk_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        card_clk, card_ce, clk_run;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int m_hi, m_lo, m_ce_hi, m_ce_lo, m_ce_idx;

    always #4 clk = ~clk;

    cardclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .card_clk(card_clk), .card_ce(card_ce),
        .clk_run(clk_run)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 195000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected < 195000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    function automatic int fac(input int p);
        int q = 1;
        if (p == 0) return 1;
        while (q * 2 <= p) q = q * 2;
        return 2 * q;
    endfunction

    // waits for a rising card_clk, measures one high and one low phase,
    // returns sitting on the first cycle of the next high phase
    task automatic measure();
        while (card_clk) @(negedge clk);
        while (!card_clk) @(negedge clk);
        m_hi = 0; m_lo = 0; m_ce_hi = 0; m_ce_lo = 0; m_ce_idx = -1;
        while (card_clk) begin
            m_hi++;
            if (card_ce) begin m_ce_hi++; m_ce_idx = m_hi; end
            @(negedge clk);
        end
        while (!card_clk) begin
            m_lo++;
            if (card_ce) m_ce_lo++;
            @(negedge clk);
        end
    endtask

    task automatic run_cfg(input int pre, input int dv);
        int d, h, f;
        d = (dv == 0) ? 2 : dv + 1;
        h = d / 2;
        f = fac(pre);
        wr(1'b0, 16'h0008);
        wr(1'b1, 16'((pre << 4) | dv));
        wr(1'b0, 16'h0002);
        measure();
        if (dv == 0) begin
            check("R3 high phase div0", m_hi, (d - h) * f);
            check("R3 low phase div0", m_lo, h * f);
        end else if (pre == 3 || pre == 5 || pre == 4095) begin
            check("R5 high phase", m_hi, (d - h) * f);
            check("R5 low phase", m_lo, h * f);
        end else begin
            check("R4 high phase", m_hi, (d - h) * f);
            check("R2 period", m_hi + m_lo, d * f);
        end
        check("R6 ce per period", m_ce_hi + m_ce_lo, 1);
        check("R6 ce last high cycle", m_ce_idx, m_hi);
        check("R7 clk_run while running", int'(clk_run), 1);
    endtask

    initial begin
        int pres[6] = '{0, 1, 2, 3, 5, 8};
        int n, seen;
        repeat (3) @(negedge clk);
        check("R1 card_clk reset", int'(card_clk), 0);
        check("R1 clk_run reset", int'(clk_run), 0);
        check("R1 card_ce reset", int'(card_ce), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", int'(clk_run | card_clk), 0);

        for (int dv = 0; dv < 16; dv++)
            for (int k = 0; k < 6; k++)
                run_cfg(pres[k], dv);
        run_cfg(4095, 1);

        // R8: stop issued on the first cycle of a high phase (pre=1, div=4)
        run_cfg(1, 4);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h0003;
        n = 0;
        do begin
            n++;
            @(negedge clk);
            wr_en = 1'b0; wr_data = '0;
        end while (card_clk);
        check("R8 full high phase on stop", n, 6);
        seen = 0;
        repeat (40) begin
            if (card_clk) seen = 1;
            @(negedge clk);
        end
        check("R8 stays low after stop", seen, 0);
        check("R8 clk_run low after stop", int'(clk_run), 0);

        // R9: soft reset while running
        run_cfg(2, 3);
        wr(1'b0, 16'h0008);
        check("R9 clk_run after soft reset", int'(clk_run), 0);
        check("R9 card_clk after soft reset", int'(card_clk), 0);
        seen = 0;
        repeat (60) begin
            if (card_clk || clk_run) seen = 1;
            @(negedge clk);
        end
        check("R9 stays stopped without start", seen, 0);

        // R9: start bit in the same write as soft reset is ignored
        wr(1'b0, 16'h000A);
        seen = 0;
        repeat (60) begin
            if (card_clk || clk_run) seen = 1;
            @(negedge clk);
        end
        check("R9 start with soft reset ignored", seen, 0);

        // R7: restart after soft reset
        wr(1'b0, 16'h0002);
        measure();
        check("R7 restart high phase", m_hi, 8);
        check("R7 restart low phase", m_lo, 8);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule